// File: doc/BRIEF.md
# Privileged Trap Entry Unit

This block performs the architectural side of taking a trap in a processor core with user, supervisor and machine privilege levels. A trap strobe arrives with a flag that separates interrupts (asynchronous) from exceptions (synchronous), a cause number, the faulting address and the PC of the trapped instruction. In that same clock edge the block decides which level handles the trap and updates that level's status bits, cause, exception PC and trap value. It also moves the privilege level to the handler's level, drops any load reservation and computes the handler's PC. One cycle later it raises a completion pulse.

Selecting which interrupt to take, returning from a trap and decoding register accesses all live elsewhere. The only other inputs are a state-load path and a reservation-set strobe. The state-load path lets those neighbours seed the privilege level and the two interrupt enables. The reservation-set strobe comes from the load-reserved logic.

Top module: `trap_entry_unit`

## Requirements
- R1: A trap is handled at supervisor level when the current privilege is user (0) or supervisor (1), the effective cause is below 32, and that cause's bit is set in the interrupt delegation mask (asynchronous trap) or the exception delegation mask (synchronous trap). Every other trap, including any cause of 32 or more, is handled at machine level (3).
- R2: On supervisor entry, `s_pie` takes the old `s_ie`, `s_pp` takes bit 0 of the old privilege, `s_ie` clears and privilege becomes 1. On machine entry, `m_pie` takes the old `m_ie`, `m_pp` takes the old privilege, `m_ie` clears and privilege becomes 3. The other level's fields and registers keep their values.
- R3: The handling level's cause register receives the asynchronous flag in bit 31, the effective cause in bits 5:0, and zeros in between.
- R4: The handling level's exception-PC register receives `cur_pc`.
- R5: The handling level's trap-value register receives `trap_addr` only for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It receives zero for every other cause and for every asynchronous trap.
- R6: `new_pc` is the handling level's vector base with bits 1:0 cleared. When the base's bits 1:0 equal 1 and the trap is asynchronous, four times the cause is added.
- R7: A synchronous cause 8 is replaced, before delegation and recording, by 8 from user level, 9 from supervisor level and 11 from machine level.
- R8: `resv_valid` clears on every trap, even when `resv_set` is high in the same cycle. It also clears on a state load that changes the privilege. Otherwise `resv_set` sets it.
- R9: All trap updates commit on the clock edge where `trap_req` is high. `done` is high for exactly the following cycle.
- R10: After reset, privilege is 3 and every status bit, record register, `new_pc`, `resv_valid` and `done` is zero.
- R11: `ld_en` without a trap loads the privilege from `ld_priv` (value 2 is stored as 0), `s_ie` from `ld_sie` and `m_ie` from `ld_mie`. A trap in the same cycle takes precedence over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap strobe |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | 6 | Raw cause number |
| trap_addr | input | 32 | Faulting address |
| cur_pc | input | 32 | PC of the trapped instruction |
| ideleg | input | 32 | Interrupt delegation mask |
| edeleg | input | 32 | Exception delegation mask |
| s_vec | input | 32 | Supervisor vector base and mode |
| m_vec | input | 32 | Machine vector base and mode |
| ld_en | input | 1 | Load privilege and enables |
| ld_priv | input | 2 | Privilege to load |
| ld_sie | input | 1 | Supervisor enable to load |
| ld_mie | input | 1 | Machine enable to load |
| resv_set | input | 1 | Set the load reservation |
| priv | output | 2 | Current privilege |
| s_ie | output | 1 | Supervisor interrupt enable |
| s_pie | output | 1 | Supervisor previous enable |
| s_pp | output | 1 | Supervisor previous privilege |
| m_ie | output | 1 | Machine interrupt enable |
| m_pie | output | 1 | Machine previous enable |
| m_pp | output | 2 | Machine previous privilege |
| s_cause | output | 32 | Supervisor cause record |
| s_epc | output | 32 | Supervisor exception PC |
| s_tval | output | 32 | Supervisor trap value |
| m_cause | output | 32 | Machine cause record |
| m_epc | output | 32 | Machine exception PC |
| m_tval | output | 32 | Machine trap value |
| new_pc | output | 32 | Handler PC |
| resv_valid | output | 1 | Load reservation held |
| done | output | 1 | Trap committed last cycle |

## Verification
A wrong privilege or enable bit is not confined to one trap: it changes the previous-privilege and previous-enable values of the next trap. A wrong privilege can also send the next trap to the wrong level. That appears at the ports two cycles later, as a record written at the other level. A wrong routing or cause remap shows one cycle after the strobe, in which level's cause, exception-PC and trap-value registers changed and in `new_pc`. The sweep covers every cause number under every privilege, both trap kinds and two delegation patterns. In each case it checks the record of both levels, so a write to the wrong side is caught in the cycle after the strobe.

// File: rtl/trap_pkg.sv
package trap_pkg;
    parameter int XLEN    = 32;
    parameter int CAUSE_W = 6;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    typedef struct packed {
        logic               to_s;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    tval;
    } route_t;

    // synchronous causes whose record keeps the faulting address
    function automatic logic keeps_addr(input logic [CAUSE_W-1:0] c);
        case (c)
            6'd0, 6'd1, 6'd4, 6'd5, 6'd6, 6'd7, 6'd12, 6'd13, 6'd15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // environment call code seen from a given privilege
    function automatic logic [CAUSE_W-1:0] call_code(input logic [1:0] p);
        case (p)
            2'd0:    return CAUSE_W'(8);
            2'd1:    return CAUSE_W'(9);
            2'd2:    return CAUSE_W'(10);
            default: return CAUSE_W'(11);
        endcase
    endfunction
endpackage

// File: rtl/trap_router.sv
module trap_router
    import trap_pkg::*;
(
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [XLEN-1:0]    addr_i,
    input  logic [1:0]         priv_i,
    input  logic [XLEN-1:0]    ideleg_i,
    input  logic [XLEN-1:0]    edeleg_i,
    output route_t             route_o
);
    localparam int IDX_W = $clog2(XLEN);

    logic [CAUSE_W-1:0] eff;
    logic [XLEN-1:0]    mask;
    logic               in_range;

    always_comb begin
        eff = (!async_i && cause_i == CAUSE_W'(8)) ? call_code(priv_i) : cause_i;
        mask = async_i ? ideleg_i : edeleg_i;
        in_range = 32'(eff) < 32'(XLEN);
        route_o.cause = eff;
        route_o.to_s  = (priv_i != PRIV_M) && in_range && mask[eff[IDX_W-1:0]];
        route_o.tval  = (!async_i && keeps_addr(eff)) ? addr_i : '0;
    end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
    import trap_pkg::*;
(
    input  logic [XLEN-1:0]    base_i,
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [XLEN-1:0]    pc_o
);
    logic [XLEN-1:0] offs;

    always_comb begin
        offs = (async_i && base_i[1:0] == 2'd1) ? XLEN'({cause_i, 2'b00}) : '0;
        pc_o = {base_i[XLEN-1:2], 2'b00} + offs;
    end
endmodule

// File: rtl/trap_level_regs.sv
module trap_level_regs
    import trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    tval_i,
    output logic [XLEN-1:0]    cause_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [XLEN-1:0]    tval_o
);
    localparam int PAD_W = XLEN - 1 - CAUSE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_o <= '0;
            epc_o   <= '0;
            tval_o  <= '0;
        end else if (wr_i) begin
            cause_o <= {async_i, {PAD_W{1'b0}}, cause_i};
            epc_o   <= pc_i;
            tval_o  <= tval_i;
        end
    end

    p_epc_capture_r4: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> epc_o == $past(pc_i));
    p_cause_flag_r3: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> cause_o[XLEN-1] == $past(async_i));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(cause_o) && $stable(epc_o) && $stable(tval_o));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               trap_req,
    input  logic               trap_async,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    ideleg,
    input  logic [XLEN-1:0]    edeleg,
    input  logic [XLEN-1:0]    s_vec,
    input  logic [XLEN-1:0]    m_vec,
    input  logic               ld_en,
    input  logic [1:0]         ld_priv,
    input  logic               ld_sie,
    input  logic               ld_mie,
    input  logic               resv_set,
    output logic [1:0]         priv,
    output logic               s_ie,
    output logic               s_pie,
    output logic               s_pp,
    output logic               m_ie,
    output logic               m_pie,
    output logic [1:0]         m_pp,
    output logic [XLEN-1:0]    s_cause,
    output logic [XLEN-1:0]    s_epc,
    output logic [XLEN-1:0]    s_tval,
    output logic [XLEN-1:0]    m_cause,
    output logic [XLEN-1:0]    m_epc,
    output logic [XLEN-1:0]    m_tval,
    output logic [XLEN-1:0]    new_pc,
    output logic               resv_valid,
    output logic               done
);
    localparam int LEVELS = 2;  // index 0 = supervisor, 1 = machine

    route_t          rt;
    logic [XLEN-1:0] vec_pc;
    logic [1:0]      ld_norm;
    logic [XLEN-1:0] cause_arr [LEVELS];
    logic [XLEN-1:0] epc_arr   [LEVELS];
    logic [XLEN-1:0] tval_arr  [LEVELS];

    trap_router u_router (
        .async_i  (trap_async),
        .cause_i  (trap_cause),
        .addr_i   (trap_addr),
        .priv_i   (priv),
        .ideleg_i (ideleg),
        .edeleg_i (edeleg),
        .route_o  (rt)
    );

    trap_vec_gen u_vec (
        .base_i  (rt.to_s ? s_vec : m_vec),
        .async_i (trap_async),
        .cause_i (rt.cause),
        .pc_o    (vec_pc)
    );

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        trap_level_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_i    (trap_req && (rt.to_s == (g == 0))),
            .async_i (trap_async),
            .cause_i (rt.cause),
            .pc_i    (cur_pc),
            .tval_i  (rt.tval),
            .cause_o (cause_arr[g]),
            .epc_o   (epc_arr[g]),
            .tval_o  (tval_arr[g])
        );
    end

    assign s_cause = cause_arr[0];
    assign s_epc   = epc_arr[0];
    assign s_tval  = tval_arr[0];
    assign m_cause = cause_arr[1];
    assign m_epc   = epc_arr[1];
    assign m_tval  = tval_arr[1];

    assign ld_norm = (ld_priv == 2'd2) ? PRIV_U : ld_priv;

    always_ff @(posedge clk) begin
        if (rst) begin
            priv       <= PRIV_M;
            s_ie       <= 1'b0;
            s_pie      <= 1'b0;
            s_pp       <= 1'b0;
            m_ie       <= 1'b0;
            m_pie      <= 1'b0;
            m_pp       <= 2'd0;
            new_pc     <= '0;
            resv_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= trap_req;
            if (trap_req) begin
                new_pc     <= vec_pc;
                resv_valid <= 1'b0;
                if (rt.to_s) begin
                    s_pie <= s_ie;
                    s_pp  <= priv[0];
                    s_ie  <= 1'b0;
                    priv  <= PRIV_S;
                end else begin
                    m_pie <= m_ie;
                    m_pp  <= priv;
                    m_ie  <= 1'b0;
                    priv  <= PRIV_M;
                end
            end else begin
                if (ld_en) begin
                    priv <= ld_norm;
                    s_ie <= ld_sie;
                    m_ie <= ld_mie;
                end
                if (ld_en && ld_norm != priv) begin
                    resv_valid <= 1'b0;
                end else if (resv_set) begin
                    resv_valid <= 1'b1;
                end
            end
        end
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> done);
    p_done_low_r9: assert property (@(posedge clk) disable iff (rst)
        !trap_req |=> !done);
    p_resv_drop_r8: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> !resv_valid);
    p_sup_entry_r2: assert property (@(posedge clk) disable iff (rst)
        trap_req && rt.to_s |=> !s_ie && priv == PRIV_S && s_pie == $past(s_ie));
    p_mach_entry_r1: assert property (@(posedge clk) disable iff (rst)
        trap_req && !rt.to_s |=> !m_ie && priv == PRIV_M && m_pp == $past(priv));
    p_mach_no_deleg_r1: assert property (@(posedge clk) disable iff (rst)
        trap_req && priv == PRIV_M |=> priv == PRIV_M);
    p_pc_align_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> new_pc[1:0] == 2'b00);
endmodule

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        trap_req, trap_async;
    logic [5:0]  trap_cause;
    logic [31:0] trap_addr, cur_pc, ideleg, edeleg, s_vec, m_vec;
    logic        ld_en, ld_sie, ld_mie, resv_set;
    logic [1:0]  ld_priv;
    logic [1:0]  priv, m_pp;
    logic        s_ie, s_pie, s_pp, m_ie, m_pie, resv_valid, done;
    logic [31:0] s_cause, s_epc, s_tval, m_cause, m_epc, m_tval, new_pc;

    int checks = 0;
    int failures = 0;

    // bench model of architectural state
    logic [1:0]  e_priv, e_mpp;
    logic        e_sie, e_spie, e_spp, e_mie, e_mpie, e_resv;
    logic [31:0] e_sc, e_se, e_st, e_mc, e_me, e_mt, e_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_unit i_trap_entry_unit (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " R1 priv"}, 32'(priv), 32'(e_priv));
        chk({tag, " R2 status"}, {26'd0, s_ie, s_pie, s_pp, m_ie, m_pie, 1'b0},
            {26'd0, e_sie, e_spie, e_spp, e_mie, e_mpie, 1'b0});
        chk({tag, " R2 m_pp"}, 32'(m_pp), 32'(e_mpp));
        chk({tag, " R3 s_cause"}, s_cause, e_sc);
        chk({tag, " R3 m_cause"}, m_cause, e_mc);
        chk({tag, " R4 epc"}, s_epc ^ {m_epc[15:0], m_epc[31:16]},
            e_se ^ {e_me[15:0], e_me[31:16]});
        chk({tag, " R5 s_tval"}, s_tval, e_st);
        chk({tag, " R5 m_tval"}, m_tval, e_mt);
        chk({tag, " R6 new_pc"}, new_pc, e_pc);
        chk({tag, " R8 resv"}, 32'(resv_valid), 32'(e_resv));
    endtask

    function automatic logic addr_cause(input int c);
        return c == 0 || c == 1 || (c >= 4 && c <= 7) || c == 12 || c == 13 || c == 15;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; trap_req = 0; trap_async = 0; trap_cause = 0; trap_addr = 0;
        cur_pc = 0; ideleg = 0; edeleg = 0; s_vec = 0; m_vec = 0;
        ld_en = 0; ld_priv = 0; ld_sie = 0; ld_mie = 0; resv_set = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        e_priv = 2'd3; e_mpp = 0; e_sie = 0; e_spie = 0; e_spp = 0; e_mie = 0;
        e_mpie = 0; e_resv = 0; e_sc = 0; e_se = 0; e_st = 0; e_mc = 0; e_me = 0;
        e_mt = 0; e_pc = 0;
        chk_all("R10 reset");
        chk("R10 done", 32'(done), 0);

        for (int j = 0; j < 2; j++) begin
            for (int p = 0; p < 4; p++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int c = 0; c < 64; c++) begin
                        int i;
                        int ec;
                        logic [1:0] np;
                        logic tos;
                        logic [31:0] msk, base;
                        i = ((j * 4 + p) * 2 + a) * 64 + c;
                        // state load (R11): priv 2 is stored as user level
                        chk("R9 done low", 32'(done), 0);
                        ld_en = 1; ld_priv = 2'(p); ld_sie = i[0]; ld_mie = i[1];
                        @(negedge clk);
                        ld_en = 0;
                        np = (p == 2) ? 2'd0 : 2'(p);
                        if (np != e_priv) e_resv = 0;
                        e_priv = np; e_sie = i[0]; e_mie = i[1];
                        chk_all("R11 load");
                        resv_set = 1;
                        @(negedge clk);
                        e_resv = 1;
                        chk("R8 set", 32'(resv_valid), 1);
                        // trap with resv_set still high: the trap must win (R8)
                        trap_req = 1; trap_async = a[0]; trap_cause = 6'(c);
                        trap_addr = 32'hDEAD_0000 ^ 32'(i);
                        cur_pc = 32'h0001_0000 + 32'(i * 4);
                        ideleg = j ? 32'hFFFF_FFFF : 32'h5555_AAAA;
                        edeleg = j ? 32'hFFFF_FFFF : 32'h0F0F_3333;
                        s_vec = 32'h1000_0000 + 32'(i << 8) + 32'(i % 4);
                        m_vec = 32'h2000_0000 + 32'(i << 8) + 32'((i + 1) % 4);
                        // expected, R7 remap first
                        ec = c;
                        if (a == 0 && c == 8) ec = (e_priv == 0) ? 8 : (e_priv == 1) ? 9 : 11;
                        msk = a ? ideleg : edeleg;
                        tos = (e_priv != 2'd3) && ec < 32 && msk[ec % 32];
                        base = tos ? s_vec : m_vec;
                        e_pc = {base[31:2], 2'b00} + ((a == 1 && base[1:0] == 2'd1) ? 32'(ec * 4) : 0);
                        if (tos) begin
                            e_spie = e_sie; e_spp = e_priv[0]; e_sie = 0; e_priv = 2'd1;
                            e_sc = (32'(a) << 31) | 32'(ec); e_se = cur_pc;
                            e_st = (a == 0 && addr_cause(ec)) ? trap_addr : 0;
                        end else begin
                            e_mpie = e_mie; e_mpp = e_priv; e_mie = 0; e_priv = 2'd3;
                            e_mc = (32'(a) << 31) | 32'(ec); e_me = cur_pc;
                            e_mt = (a == 0 && addr_cause(ec)) ? trap_addr : 0;
                        end
                        e_resv = 0;
                        @(negedge clk);
                        trap_req = 0; resv_set = 0;
                        chk_all($sformatf("R1 trap p=%0d a=%0d c=%0d j=%0d", p, a, c, j));
                        chk("R9 done", 32'(done), 1);
                        @(negedge clk);
                    end
                end
            end
        end
        // R11 precedence: trap and load together, trap wins
        ld_en = 1; ld_priv = 2'd0; ld_sie = 1; ld_mie = 1;
        trap_req = 1; trap_async = 0; trap_cause = 6'd2;
        @(negedge clk);
        ld_en = 0; trap_req = 0;
        chk("R11 trap wins priv", 32'(priv), 32'd3);
        chk("R11 trap wins m_ie", 32'(m_ie), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule